// File: doc/BRIEF.md
# Command Response Capture FIFO

This block receives the reply a card sends back on its command line once a command has gone out, keeps the reply in a shift register and hands it to the host as a short stream of 16-bit halfwords. A bit-serial input, qualified by a strobe that marks each card clock cycle, stands in for the card line. The command transmitter and the data lines belong to neighbouring blocks.

Each command opens with a one-cycle start pulse that also carries a two-bit reply kind. The block then waits for the reply's start bit while counting idle card cycles against a programmable limit. It shifts in the reply and checks its 7-bit CRC where the reply kind asks for a check. It finishes with an end-of-reply flag, and sets a timeout flag or a CRC-error flag when the reply fails. The captured reply is then offered on a valid/ready read port, most significant halfword first.

On the read port a halfword moves only on a cycle where `rd_valid` and `rd_ready` are both high. While `rd_ready` is low, `rd_data` holds steady. `rd_valid` is high only after a reply has finished, so the consumer is never stalled by the card side mid-reply.

Top module: `rsp_capture_fifo`

## Requirements
- R1: After reset, `busy`, `end_resp`, `tmo_err`, `crc_err` and `rd_valid` are 0, and the timeout limit is 255.
- R2: A start pulse with reply kind 0 (no reply) sets `end_resp` on the next cycle with `busy` low and no error flag. Every read then returns 0.
- R3: Reply kind 1 and kind 3 mean 48 bits, and kind 2 means 136 bits. While waiting, the first strobed 0 on `line_bit` is bit N-1 of the reply. Strobes outside waiting and receiving are ignored. `end_resp` rises on the cycle after the strobe of bit 0, with `busy` falling in the same cycle.
- R4: A 48-bit reply reads out as three halfwords: bits 47:32, then 31:16, then 15:0. The 32-bit argument (bits 39:8) is therefore the low byte of read 1, all of read 2 and the high byte of read 3.
- R5: A 136-bit reply reads out as eight halfwords, reply bits 127:0, highest halfword first. Each pair gives one 32-bit word, high half first. The 8 header bits 135:128 are not readable.
- R6: The CRC uses x^7+x^3+1 from a zero seed, over bits 47:8 (48-bit) or 127:8 (136-bit), and is compared with bits 7:1. A mismatch sets `crc_err` for kinds 1 and 2. Kind 3 never sets it.
- R7: While waiting, every strobed 1 counts toward the limit L. The strobe that brings the count to L, or the first strobed 1 when L is 0, ends the command with `end_resp` and `tmo_err` set and `crc_err` clear. With L-1 ones before the start bit, the reply is received normally.
- R8: A write pulse `tmo_we` loads `tmo_wdata` into the limit. The limit holds across commands until the next write.
- R9: `rd_valid` is high exactly while a finished command is held. Each handshake advances to the next halfword, and `rd_data` holds while `rd_ready` is low.
- R10: Reads beyond the last halfword of the reply kind return 0. A new start pulse returns the read position to the first halfword.
- R11: A start pulse while a reply is being awaited or received abandons it. It clears the flags and the stored bits, and the new command starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | One-cycle pulse: command sent, begin awaiting its reply |
| cmd_rtype | input | 2 | Reply kind, sampled with `cmd_start` (0 none, 1 48-bit checked, 2 136-bit, 3 48-bit unchecked) |
| tmo_we | input | 1 | Write strobe for the timeout limit |
| tmo_wdata | input | TMO_W | New timeout limit in card cycles |
| line_valid | input | 1 | Strobe: one card clock cycle on the command line |
| line_bit | input | 1 | Command line level for that cycle |
| rd_ready | input | 1 | Consumer accepts the current halfword |
| rd_valid | output | 1 | A finished reply is readable |
| rd_data | output | HW_W | Current halfword, big-endian order |
| busy | output | 1 | Awaiting or receiving a reply |
| end_resp | output | 1 | Command finished (reply taken, timed out, or none expected) |
| tmo_err | output | 1 | No start bit before the limit |
| crc_err | output | 1 | Reply CRC mismatch (checked kinds only) |

## Verification
Short replies are swept over several arguments and indexes, each sent as kind 1 and as kind 3, once with a correct CRC and once with one CRC bit flipped. This separates the check from the capture and shows that kind 3 ignores the CRC. Long replies with three payload patterns check the halfword order, the header drop and the long CRC span. Leading idle ones are swept up to one below the limit and then exactly to it, at the reset limit and at written limits of 4 and 0, which pins down the off-by-one of the timeout. Reads past the end, held `rd_ready`, kind 0 and a start pulse in mid-reply cover the read pointer and the abort path.

// File: rtl/rsp_cap_pkg.sv
package rsp_cap_pkg;

  typedef enum logic [1:0] {
    RT_NONE      = 2'd0,
    RT_SHORT_CRC = 2'd1,
    RT_LONG      = 2'd2,
    RT_SHORT_RAW = 2'd3
  } rtype_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RECV = 2'd2,
    ST_DONE = 2'd3
  } rstate_e;

  localparam int SHORT_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int HDR_BITS   = 8;
  localparam int CRC_W      = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

  // One serial step of the 7-bit CRC, feedback from the top bit.
  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

endpackage

// File: rtl/rsp_tmo_unit.sv
module rsp_tmo_unit #(
  parameter int TMO_W = 8,
  parameter logic [TMO_W-1:0] TMO_RESET = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [TMO_W-1:0] wdata,
  input  logic             arm,
  input  logic             count_en,
  output logic             expire
);
  logic [TMO_W-1:0] limit_q;
  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W:0]   cnt_next;

  assign cnt_next = {1'b0, cnt_q} + 1'b1;
  assign expire   = count_en && (cnt_next >= {1'b0, limit_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= TMO_RESET;
    end else if (we) begin
      limit_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (arm) begin
      cnt_q <= '0;
    end else if (count_en && !expire) begin
      cnt_q <= cnt_next[TMO_W-1:0];
    end
  end

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) arm |=> cnt_q == '0); // R7
  AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !we |=> $stable(limit_q)); // R8

endmodule

// File: rtl/rsp_crc7_unit.sv
module rsp_crc7_unit
  import rsp_cap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             feed,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (clr) begin
      crc_q <= '0;
    end else if (feed) begin
      crc_q <= crc7_step(crc_q, bit_in);
    end
  end

  AST_CRC_SEED: assert property (@(posedge clk) disable iff (!rst_n) clr |=> crc_q == '0); // R6

endmodule

// File: rtl/rsp_shift_capture.sv
module rsp_shift_capture #(
  parameter int SHREG_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [SHREG_W-1:0] sh_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (clr) begin
      sh_q <= '0;
    end else if (shift_en) begin
      sh_q <= {sh_q[SHREG_W-2:0], bit_in};
    end
  end

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n) (shift_en && !clr) |=> sh_q[0] == $past(bit_in)); // R3

endmodule

// File: rtl/rsp_readout.sv
module rsp_readout #(
  parameter int HW_W       = 16,
  parameter int SHORT_BITS = 48,
  parameter int LONG_PAY   = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                active,
  input  logic                is_long,
  input  logic                is_short,
  input  logic [LONG_PAY-1:0] sh_q,
  input  logic                rd_ready,
  output logic                rd_valid,
  output logic [HW_W-1:0]     rd_data
);
  localparam int LONG_HW  = LONG_PAY / HW_W;
  localparam int SHORT_HW = SHORT_BITS / HW_W;
  localparam int PTR_W    = $clog2(LONG_HW + 2);
  localparam int LIX_W    = $clog2(LONG_HW);
  localparam int SIX_W    = $clog2(SHORT_HW);

  logic [HW_W-1:0]  long_hw  [LONG_HW];
  logic [HW_W-1:0]  short_hw [SHORT_HW];
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] count;

  for (genvar g = 0; g < LONG_HW; g++) begin : g_long
    assign long_hw[g] = sh_q[LONG_PAY-1-g*HW_W -: HW_W];
  end
  for (genvar g = 0; g < SHORT_HW; g++) begin : g_short
    assign short_hw[g] = sh_q[SHORT_BITS-1-g*HW_W -: HW_W];
  end

  always_comb begin
    if (is_long)       count = PTR_W'(LONG_HW);
    else if (is_short) count = PTR_W'(SHORT_HW);
    else               count = '0;
  end

  assign rd_valid = active;

  always_comb begin
    rd_data = '0;
    if (active && (ptr_q < count)) begin
      if (is_long) rd_data = long_hw[ptr_q[LIX_W-1:0]];
      else         rd_data = short_hw[ptr_q[SIX_W-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (clr) begin
      ptr_q <= '0;
    end else if (active && rd_ready && (ptr_q != '1)) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  AST_PTR_RESTART: assert property (@(posedge clk) disable iff (!rst_n) clr |=> ptr_q == '0); // R10
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && !rd_ready && !clr) |=> $stable(rd_data)); // R9

endmodule

// File: rtl/rsp_capture_fifo.sv
module rsp_capture_fifo
  import rsp_cap_pkg::*;
#(
  parameter int TMO_W = 8,
  parameter logic [TMO_W-1:0] TMO_RESET = 8'hFF,
  parameter int HW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [1:0]       cmd_rtype,
  input  logic             tmo_we,
  input  logic [TMO_W-1:0] tmo_wdata,
  input  logic             line_valid,
  input  logic             line_bit,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic [HW_W-1:0]  rd_data,
  output logic             busy,
  output logic             end_resp,
  output logic             tmo_err,
  output logic             crc_err
);
  localparam int LONG_PAY = LONG_BITS - HDR_BITS;
  localparam int SHREG_W  = LONG_PAY;
  localparam int IDX_W    = $clog2(LONG_BITS);
  localparam logic [IDX_W-1:0] LONG_TOP   = IDX_W'(LONG_BITS - 1);
  localparam logic [IDX_W-1:0] SHORT_TOP  = IDX_W'(SHORT_BITS - 1);
  localparam logic [IDX_W-1:0] LONG_CHI   = IDX_W'(LONG_PAY - 1);
  localparam logic [IDX_W-1:0] CRC_LO     = IDX_W'(CRC_W + 1);

  rstate_e          state_q;
  rtype_e           rtype_q;
  logic [IDX_W-1:0] idx_q;
  logic             end_q, tmo_q, crc_err_q;

  logic             is_long, is_short, chk_en;
  logic             strobe_wait, strobe_recv, start_seen, tmo_count, tmo_expire;
  logic             shift_en, crc_feed, last_bit, crc_bad;
  logic [IDX_W-1:0] cur_idx, crc_hi;
  logic [CRC_W-1:0] crc_val;
  logic [SHREG_W-1:0] sh_q;

  assign is_long  = (rtype_q == RT_LONG);
  assign is_short = (rtype_q == RT_SHORT_CRC) || (rtype_q == RT_SHORT_RAW);
  assign chk_en   = (rtype_q == RT_SHORT_CRC) || (rtype_q == RT_LONG);

  assign strobe_wait = line_valid && (state_q == ST_WAIT) && !cmd_start;
  assign strobe_recv = line_valid && (state_q == ST_RECV) && !cmd_start;
  assign start_seen  = strobe_wait && !line_bit && !tmo_expire;
  assign tmo_count   = strobe_wait && line_bit;

  assign cur_idx  = start_seen ? (is_long ? LONG_TOP : SHORT_TOP) : idx_q;
  assign crc_hi   = is_long ? LONG_CHI : SHORT_TOP;
  assign shift_en = start_seen || strobe_recv;
  assign crc_feed = shift_en && (cur_idx <= crc_hi) && (cur_idx >= CRC_LO);
  assign last_bit = strobe_recv && (idx_q == '0);
  // Before the final shift, the low bits hold reply bits 7:1.
  assign crc_bad  = (sh_q[CRC_W-1:0] != crc_val);

  rsp_tmo_unit #(.TMO_W(TMO_W), .TMO_RESET(TMO_RESET)) i_tmo (
    .clk(clk), .rst_n(rst_n), .we(tmo_we), .wdata(tmo_wdata),
    .arm(cmd_start), .count_en(tmo_count), .expire(tmo_expire)
  );

  rsp_crc7_unit i_crc (
    .clk(clk), .rst_n(rst_n), .clr(cmd_start), .feed(crc_feed),
    .bit_in(line_bit), .crc_q(crc_val)
  );

  rsp_shift_capture #(.SHREG_W(SHREG_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .clr(cmd_start), .shift_en(shift_en),
    .bit_in(line_bit), .sh_q(sh_q)
  );

  rsp_readout #(.HW_W(HW_W), .SHORT_BITS(SHORT_BITS), .LONG_PAY(LONG_PAY)) i_rd (
    .clk(clk), .rst_n(rst_n), .clr(cmd_start), .active(state_q == ST_DONE),
    .is_long(is_long), .is_short(is_short), .sh_q(sh_q),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rtype_q   <= RT_NONE;
      idx_q     <= '0;
      end_q     <= 1'b0;
      tmo_q     <= 1'b0;
      crc_err_q <= 1'b0;
    end else if (cmd_start) begin
      rtype_q   <= rtype_e'(cmd_rtype);
      idx_q     <= '0;
      tmo_q     <= 1'b0;
      crc_err_q <= 1'b0;
      if (rtype_e'(cmd_rtype) == RT_NONE) begin
        state_q <= ST_DONE;
        end_q   <= 1'b1;
      end else begin
        state_q <= ST_WAIT;
        end_q   <= 1'b0;
      end
    end else begin
      case (state_q)
        ST_WAIT: begin
          if (tmo_expire) begin
            state_q <= ST_DONE;
            end_q   <= 1'b1;
            tmo_q   <= 1'b1;
          end else if (start_seen) begin
            state_q <= ST_RECV;
            idx_q   <= cur_idx - 1'b1;
          end
        end
        ST_RECV: begin
          if (last_bit) begin
            state_q   <= ST_DONE;
            end_q     <= 1'b1;
            crc_err_q <= chk_en && crc_bad;
          end else if (strobe_recv) begin
            idx_q <= idx_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign busy     = (state_q == ST_WAIT) || (state_q == ST_RECV);
  assign end_resp = end_q;
  assign tmo_err  = tmo_q;
  assign crc_err  = crc_err_q;

  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n) !(tmo_err && crc_err)); // R7
  AST_CRC_KIND: assert property (@(posedge clk) disable iff (!rst_n) crc_err |-> (rtype_q == RT_SHORT_CRC || rtype_q == RT_LONG)); // R6
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n) end_resp |-> !busy); // R3
  AST_NO_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !rd_valid); // R9
  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n) cmd_start |=> !tmo_err && !crc_err); // R11

endmodule

// File: tb/test_rsp_capture_fifo.sv
module test_rsp_capture_fifo;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [1:0]  cmd_rtype = 2'd0;
  logic        tmo_we = 1'b0;
  logic [7:0]  tmo_wdata = 8'd0;
  logic        line_valid = 1'b0;
  logic        line_bit = 1'b1;
  logic        rd_ready = 1'b0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        busy, end_resp, tmo_err, crc_err;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsp_capture_fifo i_rsp_capture_fifo (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_rtype(cmd_rtype),
    .tmo_we(tmo_we), .tmo_wdata(tmo_wdata), .line_valid(line_valid),
    .line_bit(line_bit), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .busy(busy), .end_resp(end_resp),
    .tmo_err(tmo_err), .crc_err(crc_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [135:0] r, input int hi);
    logic [6:0] c = '0;
    for (int i = hi; i >= 8; i--) begin
      logic fb = r[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [135:0] mk_short(input logic [5:0] ix, input logic [31:0] arg, input bit bad);
    logic [135:0] r = '0;
    logic [6:0] c;
    r[47:40] = {2'b00, ix};
    r[39:8]  = arg;
    c = crc7(r, 47) ^ {6'd0, bad};
    r[7:1] = c;
    r[0] = 1'b1;
    return r;
  endfunction

  function automatic logic [135:0] mk_long(input logic [119:0] pay, input bit bad);
    logic [135:0] r = '0;
    logic [6:0] c;
    r[135:128] = 8'h3F;
    r[127:8]   = pay;
    c = crc7(r, 127) ^ {6'd0, bad};
    r[7:1] = c;
    r[0] = 1'b1;
    return r;
  endfunction

  task automatic start_cmd(input logic [1:0] rt);
    @(negedge clk); cmd_start = 1'b1; cmd_rtype = rt;
    @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); line_valid = 1'b1; line_bit = b;
    @(negedge clk); line_valid = 1'b0; line_bit = 1'b1;
  endtask

  task automatic send_resp(input logic [135:0] r, input int nbits, input int idle);
    for (int k = 0; k < idle; k++) send_bit(1'b1);
    for (int i = nbits - 1; i >= 0; i--) send_bit(r[i]);
  endtask

  task automatic write_limit(input logic [7:0] v);
    @(negedge clk); tmo_we = 1'b1; tmo_wdata = v;
    @(negedge clk); tmo_we = 1'b0;
  endtask

  // Reads n halfwords plus two beyond the end; expected slices computed from r.
  task automatic read_all(input string req, input logic [135:0] r, input int kind);
    int n = (kind == 2) ? 8 : (kind == 0) ? 0 : 3;
    for (int k = 0; k < n + 2; k++) begin
      logic [15:0] exp;
      if (k >= n)         exp = 16'h0;
      else if (kind == 2) exp = 16'(r >> (112 - 16*k));
      else                exp = 16'(r >> (32 - 16*k));
      chk({req, " rd_valid"}, {31'd0, rd_valid}, 32'd1);
      chk(k >= n ? "R10 past end" : req, {16'd0, rd_data}, {16'd0, exp});
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
    end
  endtask

  task automatic check_done(input string req, input bit exp_tmo, input bit exp_crc);
    chk({req, " end_resp"}, {31'd0, end_resp}, 32'd1);
    chk({req, " busy"}, {31'd0, busy}, 32'd0);
    chk({req, " tmo_err"}, {31'd0, tmo_err}, {31'd0, exp_tmo});
    chk({req, " crc_err"}, {31'd0, crc_err}, {31'd0, exp_crc});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [135:0] r;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 end_resp", {31'd0, end_resp}, 32'd0);
    chk("R1 flags", {30'd0, tmo_err, crc_err}, 32'd0);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: strobes while idle are ignored
    send_bit(1'b0);
    chk("R3 idle ignore", {30'd0, busy, end_resp}, 32'd0);

    // R2: no reply expected
    start_cmd(2'd0);
    check_done("R2", 1'b0, 1'b0);
    read_all("R2", '0, 0);

    // R4 R6 short sweep, kinds 1 and 3, good and bad CRC
    for (int i = 0; i < 6; i++) begin
      for (int bad = 0; bad < 2; bad++) begin
        for (int kk = 0; kk < 2; kk++) begin
          logic [1:0] rt = (kk == 0) ? 2'd1 : 2'd3;
          logic [31:0] arg = (32'h1 << (i * 6)) ^ (32'h01234567 * i) ^ (bad ? 32'hA5A5_0F0F : 32'h0);
          r = mk_short(6'(i * 9 + 2), arg, bad[0]);
          start_cmd(rt);
          chk("R3 busy waiting", {31'd0, busy}, 32'd1);
          send_resp(r, 48, i);
          check_done("R6 short", 1'b0, (rt == 2'd1) && (bad == 1));
          read_all("R4 short", r, 1);
        end
      end
    end

    // R5 R6 long sweep
    for (int i = 0; i < 3; i++) begin
      for (int bad = 0; bad < 2; bad++) begin
        logic [119:0] pay = {4{30'h1234567 * (i + 1) ^ 30'(i * 30'h15555)}};
        r = mk_long(pay, bad[0]);
        start_cmd(2'd2);
        send_resp(r, 136, 2 * i);
        check_done("R6 long", 1'b0, bad == 1);
        read_all("R5 long", r, 2);
      end
    end

    // R9: back-pressure holds data, then R10 restart pointer
    r = mk_short(6'd17, 32'hCAFE_F00D, 1'b0);
    start_cmd(2'd1);
    send_resp(r, 48, 0);
    repeat (3) begin
      @(negedge clk);
      chk("R9 hold", {16'd0, rd_data}, {16'd0, r[47:32]});
    end
    rd_ready = 1'b1; @(negedge clk); rd_ready = 1'b0;
    chk("R9 advance", {16'd0, rd_data}, {16'd0, r[31:16]});
    start_cmd(2'd1);
    chk("R9 no valid busy", {31'd0, rd_valid}, 32'd0);
    send_resp(r, 48, 1);
    chk("R10 restart", {16'd0, rd_data}, {16'd0, r[47:32]});

    // R7 R8: reset limit 255
    start_cmd(2'd1);
    send_resp(r, 48, 254);
    check_done("R7 below limit", 1'b0, 1'b0);
    start_cmd(2'd1);
    for (int k = 0; k < 254; k++) send_bit(1'b1);
    chk("R7 still waiting", {31'd0, busy}, 32'd1);
    send_bit(1'b1);
    check_done("R7 timeout", 1'b1, 1'b0);

    // R8: written limit 4, held across commands
    write_limit(8'd4);
    start_cmd(2'd3);
    send_resp(r, 48, 3);
    check_done("R8 limit4 ok", 1'b0, 1'b0);
    read_all("R8 limit4 data", r, 3);
    start_cmd(2'd1);
    for (int k = 0; k < 4; k++) send_bit(1'b1);
    check_done("R8 limit4 tmo", 1'b1, 1'b0);
    write_limit(8'd0);
    start_cmd(2'd1);
    send_bit(1'b1);
    check_done("R7 limit0", 1'b1, 1'b0);
    start_cmd(2'd1);
    send_resp(r, 48, 0);
    check_done("R7 limit0 start", 1'b0, 1'b0);
    write_limit(8'd20);

    // R11: abort a long reply mid-way with a short command
    start_cmd(2'd2);
    r = mk_long({4{30'h2AAA_AAAA}}, 1'b0);
    for (int i = 135; i > 100; i--) send_bit(r[i]);
    r = mk_short(6'd5, 32'h0BAD_BEEF, 1'b0);
    start_cmd(2'd1);
    chk("R11 flags cleared", {29'd0, end_resp, tmo_err, crc_err}, 32'd0);
    send_resp(r, 48, 2);
    check_done("R11 after abort", 1'b0, 1'b0);
    read_all("R11 data", r, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule